// File: doc/BRIEF.md
# Stereo Sound Channel Mixer

This block takes the 4-bit sample outputs of four sound channels and combines them into a left and a right output sample. Two configuration registers shape the mix. The level register holds one volume field for each side. The routing register holds one enable bit for each pairing of a channel and a side. A master sound enable input silences both sides at once.

On each sample strobe, each side adds up the channels routed to it and divides that sum by four, dropping the remainder. The result is captured in that side's output register. If that side's volume field is zero, or the master enable is low, the side captures zero instead. The volume field acts only as an on/off gate; it does not scale the level. Between strobes the outputs hold their value. A register write lands in the register at once, but it reaches the outputs only at the next strobe.

Top module: `stereo_mix_core`

## Requirements
- R1: After reset both outputs are zero and both configuration registers are zero, so a strobe with full-scale inputs and no writes yields zero on both sides.
- R2: A write with `cfg_sel`=0 loads the level register. The left volume field is bits 2..0 and the right volume field is bits 6..4. Bits 3 and 7 are ignored.
- R3: A write with `cfg_sel`=1 loads the routing register. Bit k (k=0..3) routes channel k+1 to the left side, and bit k+4 routes channel k+1 to the right side. Channel k+1 occupies `ch_samp` bits 4k+3..4k.
- R4: On a strobe, each enabled side outputs the floor of (sum of its routed channel samples) / 4.
- R5: A strobe taken while `snd_en` is low drives both outputs to zero.
- R6: A strobe taken while a side's volume field is zero drives that side to zero and leaves the other side's mix unaffected.
- R7: Outputs change only on a clock edge where `samp_stb` is high and hold their value otherwise, whatever the inputs do.
- R8: A register write changes no output by itself. A strobe in the same cycle as a write uses the old register value, and the new value applies from the next strobe.
- R9: Four full-scale channels (15 each) routed to one side yield 15 with no wrap of the internal sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| snd_en | input | 1 | Master sound enable |
| samp_stb | input | 1 | Sample strobe; outputs are captured on this cycle's edge |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 1 | Register select: 0 level, 1 routing |
| cfg_wdata | input | 8 | Register write data |
| ch_samp | input | 16 | Four channel samples, channel 1 in bits 3..0 |
| out_left | output | 4 | Left mixed sample |
| out_right | output | 4 | Right mixed sample |

## Verification
A wrong bit in the level or routing register shows up as a wrong or zeroed sample on one side, on the first strobe after the fault. Between strobes the fault stays invisible, because the outputs hold. The bench therefore strobes after every configuration change and uses channel values whose sums are distinct. That way a channel routed to the wrong side, or a wrong volume bit, yields a different number on the very next strobe. Holding checks between strobes catch an output register that updates too early or too often.

// File: rtl/stereo_mix_pkg.sv
package stereo_mix_pkg;
   typedef enum logic {
      SEL_LEVEL = 1'b0,
      SEL_ROUTE = 1'b1
   } cfg_sel_e;

   localparam int NUM_SIDES  = 2;
   localparam int VOL_STRIDE = 4;
endpackage

// File: rtl/mix_cfg_regs.sv
module mix_cfg_regs
   import stereo_mix_pkg::*;
#(
   parameter int CFG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic             sel,
   input  logic [CFG_W-1:0] wdata,
   output logic [CFG_W-1:0] level_q,
   output logic [CFG_W-1:0] route_q
);
   cfg_sel_e sel_e;
   assign sel_e = cfg_sel_e'(sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
         route_q <= '0;
      end else if (we) begin
         if (sel_e == SEL_LEVEL) level_q <= wdata;
         else                    route_q <= wdata;
      end
   end

   // R8: registers move only on a write
   assert_cfg_stable_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(level_q) && $stable(route_q)));
endmodule

// File: rtl/mix_side.sv
module mix_side #(
   parameter int NUM_CH = 4,
   parameter int SAMP_W = 4,
   parameter int VOL_W  = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     stb,
   input  logic                     en,
   input  logic [VOL_W-1:0]         vol,
   input  logic [NUM_CH-1:0]        mask,
   input  logic [NUM_CH*SAMP_W-1:0] samp,
   output logic [SAMP_W-1:0]        out
);
   localparam int SHIFT = (NUM_CH > 1) ? $clog2(NUM_CH) : 0;
   localparam int SUM_W = SAMP_W + SHIFT;

   logic [SUM_W-1:0] term [NUM_CH];
   logic [SUM_W-1:0] acc;
   logic             side_on;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_term
      assign term[i] = mask[i] ? SUM_W'(samp[i*SAMP_W +: SAMP_W]) : '0;
   end

   always_comb begin
      acc = '0;
      for (int i = 0; i < NUM_CH; i++) acc = acc + term[i];
   end

   assign side_on = en && (vol != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   out <= '0;
      else if (stb) out <= side_on ? SAMP_W'(acc >> SHIFT) : '0;
   end

   assert_hold_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(out));
   assert_master_off_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !en) |=> (out == '0));
   assert_vol_zero_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb && (vol == '0)) |=> (out == '0));
   assert_no_route_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (stb && (mask == '0)) |=> (out == '0));
endmodule

// File: rtl/stereo_mix_core.sv
module stereo_mix_core
   import stereo_mix_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int SAMP_W = 4,
   parameter int VOL_W  = 3,
   parameter int CFG_W  = 2 * NUM_CH
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     snd_en,
   input  logic                     samp_stb,
   input  logic                     cfg_we,
   input  logic                     cfg_sel,
   input  logic [CFG_W-1:0]         cfg_wdata,
   input  logic [NUM_CH*SAMP_W-1:0] ch_samp,
   output logic [SAMP_W-1:0]        out_left,
   output logic [SAMP_W-1:0]        out_right
);
   if (NUM_CH < 1) $error("NUM_CH must be at least 1");
   if (VOL_W < 1 || VOL_W > VOL_STRIDE) $error("VOL_W out of range");
   if (CFG_W < 2 * NUM_CH || CFG_W < VOL_STRIDE + VOL_W) $error("CFG_W too narrow");

   logic [CFG_W-1:0]  level_q, route_q;
   logic [SAMP_W-1:0] side_out [NUM_SIDES];

   mix_cfg_regs #(.CFG_W(CFG_W)) i_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel),
      .wdata(cfg_wdata), .level_q(level_q), .route_q(route_q)
   );

   for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
      mix_side #(.NUM_CH(NUM_CH), .SAMP_W(SAMP_W), .VOL_W(VOL_W)) i_side (
         .clk(clk), .rst_n(rst_n), .stb(samp_stb), .en(snd_en),
         .vol(level_q[s*VOL_STRIDE +: VOL_W]),
         .mask(route_q[s*NUM_CH +: NUM_CH]),
         .samp(ch_samp), .out(side_out[s])
      );
   end

   assign out_left  = side_out[0];
   assign out_right = side_out[1];

   // R8: a write without a strobe leaves both outputs alone
   assert_write_no_effect_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !samp_stb) |=> ($stable(out_left) && $stable(out_right)));
endmodule

// File: tb/test_stereo_mix_core.sv
module test_stereo_mix_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        snd_en = 1'b0;
   logic        samp_stb = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [7:0]  cfg_wdata = '0;
   logic [15:0] ch_samp = '0;
   logic [3:0]  out_left, out_right;

   int n_cmp = 0;
   int n_bad = 0;
   logic [7:0] sh_level = '0, sh_route = '0;
   logic [7:0] exp_q [$];
   logic [7:0] exp_last = '0;
   string      tag_q [$];

   always #5 clk = ~clk;

   stereo_mix_core i_stereo_mix_core (
      .clk(clk), .rst_n(rst_n), .snd_en(snd_en), .samp_stb(samp_stb),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .ch_samp(ch_samp), .out_left(out_left), .out_right(out_right)
   );

   function automatic logic [3:0] side_model(input logic [2:0] vol, input logic [3:0] msk,
                                             input logic en, input logic [15:0] ch);
      int sum = 0;
      if (!en || vol == 3'd0) return 4'd0;
      for (int k = 0; k < 4; k++) if (msk[k]) sum += int'(ch[4*k +: 4]);
      return 4'(sum / 4);
   endfunction

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: L/R actual %0d/%0d expected %0d/%0d", tag,
                  act[7:4], act[3:0], exp[7:4], exp[3:0]);
      end
   endtask

   task automatic write_reg(input logic sel, input logic [7:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
      if (sel) sh_route = val; else sh_level = val;
   endtask

   task automatic push_exp(input string tag);
      exp_q.push_back({side_model(sh_level[2:0], sh_route[3:0], snd_en, ch_samp),
                       side_model(sh_level[6:4], sh_route[7:4], snd_en, ch_samp)});
      tag_q.push_back(tag);
   endtask

   task automatic strobe(input string tag);
      @(negedge clk);
      samp_stb = 1'b1;
      push_exp(tag);
      @(negedge clk);
      samp_stb = 1'b0;
   endtask

   // R8: strobe and write in one cycle; old register value applies
   task automatic strobe_write(input string tag, input logic sel, input logic [7:0] val);
      @(negedge clk);
      samp_stb = 1'b1; cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      push_exp(tag);
      @(negedge clk);
      samp_stb = 1'b0; cfg_we = 1'b0;
      if (sel) sh_route = val; else sh_level = val;
   endtask

   task automatic check_hold(input string tag, input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         check(tag, {out_left, out_right}, exp_last);
      end
   endtask

   // monitor: scoreboard pop after each strobe edge
   initial begin
      forever begin
         @(posedge clk);
         if (samp_stb === 1'b1) begin
            #1;
            if (exp_q.size() == 0) begin
               check("monitor underflow", {out_left, out_right}, 8'hxx);
            end else begin
               exp_last = exp_q.pop_front();
               check(tag_q.pop_front(), {out_left, out_right}, exp_last);
            end
         end
      end
   end

   initial begin
      #2_000_000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset outputs", {out_left, out_right}, 8'h00);
      rst_n = 1'b1;
      snd_en = 1'b1;
      ch_samp = 16'hFFFF;
      strobe("R1 registers reset to zero");

      write_reg(1'b0, 8'h77);
      ch_samp = {4'd4, 4'd3, 4'd2, 4'd1};
      write_reg(1'b1, 8'h0F);
      strobe("R3 R4 all to left");
      write_reg(1'b1, 8'hF0);
      strobe("R3 all to right");

      ch_samp = {4'd3, 4'd9, 4'd7, 4'd15};
      write_reg(1'b1, 8'hA5);
      strobe("R3 R4 split routing");
      write_reg(1'b1, 8'h5A);
      strobe("R3 swapped routing");

      ch_samp = {4'd0, 4'd1, 4'd1, 4'd1};
      write_reg(1'b1, 8'hFF);
      strobe("R4 floor of small sum");
      ch_samp = 16'hFFFF;
      strobe("R9 full scale no wrap");

      snd_en = 1'b0;
      strobe("R5 master off");
      snd_en = 1'b1;

      ch_samp = {4'd8, 4'd6, 4'd5, 4'd2};
      write_reg(1'b0, 8'h70);
      strobe("R6 left volume zero");
      write_reg(1'b0, 8'h07);
      strobe("R6 right volume zero");
      write_reg(1'b0, 8'h88);
      strobe("R2 bits 3 and 7 ignored");
      write_reg(1'b0, 8'h15);
      strobe("R2 small nonzero volumes");

      ch_samp = 16'h3C5A;
      check_hold("R7 hold between strobes", 4);
      ch_samp = 16'h0000;
      snd_en = 1'b0;
      check_hold("R7 hold with inputs changed", 3);
      snd_en = 1'b1;

      write_reg(1'b1, 8'h00);
      check_hold("R8 write alone changes nothing", 2);
      ch_samp = {4'd8, 4'd6, 4'd5, 4'd2};
      write_reg(1'b1, 8'h3C);
      strobe_write("R8 same-cycle write uses old value", 1'b1, 8'hC3);
      strobe("R8 new value at next strobe");
      strobe_write("R8 level write same cycle", 1'b0, 8'h00);
      strobe("R6 R8 both volumes zero");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) check("scoreboard drain", 8'(exp_q.size()), 8'h00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule